// File: doc/BRIEF.md
# Reference-Counted Isolation and Power-Down Sequencer

This block owns the isolation state of one pad-control power domain. Any number of clients share the domain; each asks for it with a one-cycle enable pulse and gives it up with a one-cycle disable pulse. A saturating use counter tracks how many clients hold the domain. Only the first enable (count 0 to 1) and the last disable (count 1 to 0) touch the hardware. Every other request just moves the count.

On the first enable the block lifts three isolation controls one at a time: the clamp, then the early clamp, then core power-down. After that it releases the PHY reset. On the last disable it does the same four actions in exactly the reverse order, asserting the PHY reset first. Consecutive actions are spaced by a settle time of `SETTLE` clock cycles (default 16, must be at least 1).

While a sequence runs, `busy` is high and any request is dropped without effect, so a client retries once `busy` falls. A one-cycle `done` pulse marks the end of each sequence. One-cycle error pulses flag a disable with no holder and an enable at the count ceiling.

Top module: `pwr_clamp_seq`

## Requirements
- R1: After reset `use_count` is 0, `iso_ctrl` is 3'b111, `phy_rst` is 1, and `busy`, `done`, `err_unbal` and `err_ovf` are 0. In `iso_ctrl`, bit 2 is core power-down, bit 1 is the early clamp and bit 0 is the clamp, all active high.
- R2: An enable pulse while idle with count 0 makes the count 1. It clears the clamp at the edge that samples the request. It clears the early clamp `SETTLE` cycles later and core power-down 2·`SETTLE` cycles later. At 3·`SETTLE` cycles it releases `phy_rst`, pulses `done` for one cycle and drops `busy`. `busy` is high from the first edge until that point.
- R3: A disable pulse while idle with count 1 makes the count 0. It asserts `phy_rst` at the sampling edge, then sets core power-down, the early clamp and the clamp at `SETTLE`, 2·`SETTLE` and 3·`SETTLE` cycles. It pulses `done` and drops `busy` with the last action.
- R4: An enable while idle with a count between 1 and the maximum minus one adds one to the count and changes no other output.
- R5: A disable while idle with a count above 1 subtracts one and changes no other output.
- R6: A disable while idle with count 0 leaves the count at 0, changes no control output and pulses `err_unbal` for one cycle, in the cycle after the sampling edge.
- R7: Any request sampled while `busy` is high is ignored: the count, the controls and both error outputs are unaffected.
- R8: An enable while idle with the count at its maximum (255 by default) leaves the count there, changes no control output and pulses `err_ovf` for one cycle.
- R9: Enable and disable asserted in the same cycle are both ignored.
- R10: The pair {`phy_rst`, `iso_ctrl`} only ever takes the values 4'b1111, 4'b1110, 4'b1100, 4'b1000 and 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req | input | 1 | One-cycle enable request |
| dis_req | input | 1 | One-cycle disable request |
| iso_ctrl | output | 3 | {core power-down, early clamp, clamp}, active high |
| phy_rst | output | 1 | PHY reset, active high |
| busy | output | 1 | Sequence in progress; requests are dropped |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| use_count | output | CNT_W | Current number of holders |
| err_unbal | output | 1 | One-cycle pulse: disable with no holder |
| err_ovf | output | 1 | One-cycle pulse: enable at the count ceiling |

## Verification
The count and the error pulses are due one cycle after the edge that samples a request. The first control action of a sequence is also due one cycle after that edge. The later actions follow at exact multiples of `SETTLE` cycles after it, and `done` arrives together with the last one. The bench drives inputs and compares outputs only on falling edges. Its reference model advances exactly once per rising edge, so every output is compared in the cycle its due time falls in, never earlier or later. Directed phases hit the zero and ceiling counts and requests made during a sequence. A seeded random phase mixes single and simultaneous requests and also checks that the control outputs stay in their legal ordering.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned N_STEPS    = 4;
  localparam int unsigned BIT_CLAMP  = 0;
  localparam int unsigned BIT_EARLY  = 1;
  localparam int unsigned BIT_CORE   = 2;
  localparam int unsigned BIT_PHYRST = 3;
endpackage

// File: rtl/pcs_refcnt.sv
module pcs_refcnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             dis_i,
  input  logic             busy_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             go_up_o,
  output logic             go_dn_o,
  output logic             err_unbal_o,
  output logic             err_ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             unbal_q, ovf_q;
  logic             take_en, take_dis;

  assign take_en  = en_i & ~dis_i & ~busy_i;
  assign take_dis = dis_i & ~en_i & ~busy_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      unbal_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      unbal_q <= 1'b0;
      ovf_q   <= 1'b0;
      if (take_en) begin
        if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
        else                  cnt_q <= cnt_q + CNT_ONE;
      end
      if (take_dis) begin
        if (cnt_q == '0) unbal_q <= 1'b1;
        else             cnt_q   <= cnt_q - CNT_ONE;
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign go_up_o     = take_en & (cnt_q == '0);
  assign go_dn_o     = take_dis & (cnt_q == CNT_ONE);
  assign err_unbal_o = unbal_q;
  assign err_ovf_o   = ovf_q;

  p_unbal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_i && !en_i && !busy_i && cnt_q == '0) |=> (unbal_q && cnt_q == '0));
  p_ovf_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !dis_i && !busy_i && cnt_q == CNT_MAX) |=> (ovf_q && cnt_q == CNT_MAX));
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(cnt_q) && !unbal_q && !ovf_q));
  p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !dis_i && !busy_i && cnt_q != '0 && cnt_q != CNT_MAX)
      |=> (cnt_q == $past(cnt_q) + CNT_ONE));
  p_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && dis_i) |=> ($stable(cnt_q) && !unbal_q && !ovf_q));
endmodule

// File: rtl/pcs_stepper.sv
module pcs_stepper #(
  parameter int unsigned SETTLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic go_dn_i,
  output logic busy_o,
  output logic act_o,
  output logic [$clog2(pcs_pkg::N_STEPS)-1:0] act_k_o,
  output logic dn_o,
  output logic done_o
);
  localparam int unsigned STEP_W = $clog2(pcs_pkg::N_STEPS);
  localparam int unsigned TMR_W  = (SETTLE < 2) ? 1 : $clog2(SETTLE);
  localparam logic [TMR_W-1:0]  TMR_LOAD  = TMR_W'(SETTLE - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(pcs_pkg::N_STEPS - 1);

  logic              busy_q, dir_q, done_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      tmr_q  <= '0;
      step_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        busy_q <= 1'b1;
        dir_q  <= go_dn_i;
        step_q <= STEP_W'(1);
        tmr_q  <= TMR_LOAD;
      end else if (busy_q) begin
        if (tmr_q != '0) begin
          tmr_q <= tmr_q - TMR_W'(1);
        end else if (step_q == STEP_LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + STEP_W'(1);
          tmr_q  <= TMR_LOAD;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign act_o   = go_i | (busy_q & (tmr_q == '0));
  assign act_k_o = go_i ? '0 : step_q;
  assign dn_o    = go_i ? go_dn_i : dir_q;

  p_go_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_q);
  p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
endmodule

// File: rtl/pwr_clamp_seq.sv
module pwr_clamp_seq #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned SETTLE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req,
  input  logic             dis_req,
  output logic [2:0]       iso_ctrl,
  output logic             phy_rst,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] use_count,
  output logic             err_unbal,
  output logic             err_ovf
);
  import pcs_pkg::*;
  localparam int unsigned PAD_W  = N_STEPS;
  localparam int unsigned STEP_W = $clog2(N_STEPS);

  logic              go_up, go_dn, act, dn;
  logic [STEP_W-1:0] act_k;
  logic [PAD_W-1:0]  pad_q, pad_d;

  pcs_refcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_i(en_req), .dis_i(dis_req), .busy_i(busy),
    .cnt_o(use_count), .go_up_o(go_up), .go_dn_o(go_dn),
    .err_unbal_o(err_unbal), .err_ovf_o(err_ovf)
  );

  pcs_stepper #(.SETTLE(SETTLE)) u_step (
    .clk(clk), .rst_n(rst_n), .go_i(go_up | go_dn), .go_dn_i(go_dn),
    .busy_o(busy), .act_o(act), .act_k_o(act_k), .dn_o(dn), .done_o(done)
  );

  // Bit i is released at step i going up and re-applied at step N-1-i going down.
  for (genvar i = 0; i < PAD_W; i++) begin : g_pad
    always_comb begin
      pad_d[i] = pad_q[i];
      if (act && !dn && act_k == STEP_W'(i))
        pad_d[i] = 1'b0;
      else if (act && dn && act_k == STEP_W'(PAD_W - 1 - i))
        pad_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pad_q <= '1;
    else        pad_q <= pad_d;
  end

  assign iso_ctrl = {pad_q[BIT_CORE], pad_q[BIT_EARLY], pad_q[BIT_CLAMP]};
  assign phy_rst  = pad_q[BIT_PHYRST];

  p_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_q == 4'b1111) || (pad_q == 4'b1110) || (pad_q == 4'b1100) ||
    (pad_q == 4'b1000) || (pad_q == 4'b0000));
  p_up_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go_up |=> (iso_ctrl == 3'b110 && phy_rst));
  p_dn_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go_dn |=> (iso_ctrl == 3'b000 && phy_rst));
  p_quiet_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req && !dis_req && !busy && use_count != '0) |=> $stable(pad_q));
  p_quiet_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_req && !en_req && !busy && use_count > CNT_W'(1)) |=> $stable(pad_q));
endmodule

// File: tb/sim_pwr_clamp_seq.sv
module sim_pwr_clamp_seq;
  localparam int S    = 16;
  localparam int CMAX = 255;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_req = 1'b0, dis_req = 1'b0;
  logic [2:0] iso_ctrl;
  logic       phy_rst, busy, done, err_unbal, err_ovf;
  logic [7:0] use_count;

  int checks = 0, errors = 0;
  bit finished = 0;

  // Reference model state: {phy_rst, core, early, clamp}
  int       m_cnt;
  logic [3:0] m_pad;
  bit       m_busy, m_dn, m_done, m_eu, m_eo;
  int       m_e;

  always #4 clk = ~clk;

  pwr_clamp_seq #(.CNT_W(8), .SETTLE(S)) u0 (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .iso_ctrl(iso_ctrl), .phy_rst(phy_rst), .busy(busy), .done(done),
    .use_count(use_count), .err_unbal(err_unbal), .err_ovf(err_ovf)
  );

  // Step k of a sequence: up clears clamp, early, core, reset in turn;
  // down sets reset, core, early, clamp in turn.
  function automatic logic [3:0] apply_step(logic [3:0] st, bit down, int k);
    logic [3:0] r = st;
    if (down) r[3-k] = 1'b1;
    else      r[k]   = 1'b0;
    return r;
  endfunction

  function automatic bit legal_pad(logic [3:0] p);
    return (p == 4'b1111) || (p == 4'b1110) || (p == 4'b1100) ||
           (p == 4'b1000) || (p == 4'b0000);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(use_count == m_cnt[7:0], tag, "use_count", use_count, m_cnt);
    chk({phy_rst, iso_ctrl} == m_pad, tag, "controls", {phy_rst, iso_ctrl}, m_pad);
    chk(busy == m_busy, tag, "busy", busy, m_busy);
    chk(done == m_done, tag, "done", done, m_done);
    chk(err_unbal == m_eu, tag, "err_unbal", err_unbal, m_eu);
    chk(err_ovf == m_eo, tag, "err_ovf", err_ovf, m_eo);
    chk(legal_pad({phy_rst, iso_ctrl}), "R10", "ordering", {phy_rst, iso_ctrl}, m_pad);
  endtask

  task automatic model_next(bit en, bit dis);
    m_done = 0; m_eu = 0; m_eo = 0;
    if (m_busy) begin
      m_e++;
      if (m_e % S == 0) begin
        m_pad = apply_step(m_pad, m_dn, m_e / S);
        if (m_e / S == 3) begin m_busy = 0; m_done = 1; end
      end
    end else if (en && !dis) begin
      if (m_cnt == CMAX) m_eo = 1;
      else begin
        if (m_cnt == 0) begin
          m_busy = 1; m_e = 0; m_dn = 0; m_pad = apply_step(m_pad, 0, 0);
        end
        m_cnt++;
      end
    end else if (dis && !en) begin
      if (m_cnt == 0) m_eu = 1;
      else begin
        if (m_cnt == 1) begin
          m_busy = 1; m_e = 0; m_dn = 1; m_pad = apply_step(m_pad, 1, 0);
        end
        m_cnt--;
      end
    end
  endtask

  // One cycle: compare what the last rising edge produced, then drive.
  task automatic step(bit en, bit dis, string tag);
    @(negedge clk);
    compare(tag);
    en_req  = en;
    dis_req = dis;
    model_next(en, dis);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cnt = 0; m_pad = 4'hF; m_busy = 0; m_dn = 0; m_done = 0;
    m_eu = 0; m_eo = 0; m_e = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    idle(3, "R1");
    // R6: disable with no holder
    step(0, 1, "R6");
    idle(2, "R6");
    // R9: simultaneous requests
    step(1, 1, "R9");
    idle(2, "R9");
    // R2 power-up sequence with R7 requests injected mid-sequence
    step(1, 0, "R2");
    idle(5, "R2");
    step(1, 0, "R7");
    idle(3, "R7");
    step(0, 1, "R7");
    step(1, 1, "R7");
    idle(3 * S, "R2");
    // R4 / R5 counting without output change
    for (int i = 0; i < 3; i++) begin step(1, 0, "R4"); step(0, 0, "R4"); end
    for (int i = 0; i < 3; i++) begin step(0, 1, "R5"); step(0, 0, "R5"); end
    // R3 power-down sequence, with a request during it
    step(0, 1, "R3");
    idle(S + 2, "R3");
    step(1, 0, "R7");
    idle(2 * S + 2, "R3");
    // R8: climb to the ceiling and overflow
    step(1, 0, "R8");
    idle(3 * S + 2, "R8");
    for (int i = 0; i < CMAX - 1; i++) step(1, 0, "R8");
    step(1, 0, "R8");
    step(0, 0, "R8");
    step(1, 0, "R8");
    idle(2, "R8");
    for (int i = 0; i < CMAX - 1; i++) step(0, 1, "R5");
    step(0, 1, "R3");
    idle(3 * S + 2, "R3");
    // R10: seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 16);
      step(r < 3, (r >= 3 && r < 6), "R10");
      if (r == 6) step(1, 1, "R9");
    end
    idle(3 * S + 4, "R10");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule